// File: doc/BRIEF.md
# Index Pulse Rotation Monitor

This block watches the index-hole sensor of a floppy drive and, on request, answers two questions. First, is there a disk in the drive, and is it turning? Second, how fast is it turning, in revolutions per minute? A single start pulse begins a run. The block first classifies presence by timing how long the sensor stays at its current level. If the disk turns, the block then measures speed over a fixed window and reports the result.

Time is supplied as a one-cycle tick pulse, nominally every 100 ms. All timeouts and windows are counted in ticks. For speed, the block waits until the hole is open. It then counts each open-to-closed transition of the sensor until the window expires. The count is shifted left by an amount tied to the selected window, so the reported value is in RPM. A drive at the nominal 300 RPM yields five index pulses per second.

Top module: `idx_rot_monitor`

## Requirements
- R1: `index_raw` passes through a two-flop synchronizer before any decision. A level applied before a rising edge can first influence state at the third rising edge.
- R2: The sensor is open when `index_raw` = 1. If the synchronized sensor stays open for OPEN_TMO ticks after a start, the run ends with `presence` = 2'b01 (no disk) and `rpm` = 0.
- R3: If the synchronized sensor stays closed (0) after a start, the run ends with `presence` = 2'b10 (stopped) and `rpm` = 0. The closed timeout is 3×OPEN_TMO ticks, three times the open timeout.
- R4: If the synchronized sensor changes level before the timeout, `presence` becomes 2'b11 (spinning) and a speed measurement follows in the same run.
- R5: A measurement waits for the sensor to be open. It then counts one revolution per open-to-closed transition until the window expires. A transition in the same cycle as the final tick is counted.
- R6: With `win_sel` = 0 the window is 75 ticks and `rpm` = count×8, so results are multiples of 8.
- R7: With `win_sel` = 1 the window is 300 ticks and `rpm` = count×2. With `win_sel` = 2 or 3 the window is 600 ticks and `rpm` = count.
- R8: `busy` is high from the cycle after an accepted start until the run ends. At that point `done` rises, and `done`, `presence` and `rpm` hold until the next accepted start, which clears them.
- R9: A start pulse while `busy` is high is ignored, including any change of `win_sel` presented with it.
- R10: After reset, `presence` = 2'b00, `rpm` = 0, `done` = 0 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| index_raw | input | 1 | Index sensor, 1 = hole open, asynchronous |
| tick | input | 1 | One-cycle time-base pulse (100 ms nominal) |
| start | input | 1 | Begin a run when idle |
| win_sel | input | 2 | Window select: 0 = 75, 1 = 300, 2/3 = 600 ticks |
| presence | output | 2 | 00 none yet, 01 no disk, 10 stopped, 11 spinning |
| rpm | output | RPM_W | Measured speed in RPM |
| done | output | 1 | Run finished, result valid |
| busy | output | 1 | Run in progress |

## Verification
The hardest situations to reach are races at the edges of a timeout. One is a sensor level that lasts just less, or just more, than a presence timeout. The other is an index edge that lands in the cycle of the final window tick. The stimulus uses slow index waveforms with controlled starting phase. An open period longer than the open timeout must read as no disk. A closed period longer than the open timeout but shorter than the closed timeout must read as spinning. A behavioural reference model advances with every clock, so a boundary coincidence is compared cycle by cycle wherever it falls.

// File: rtl/idxmon_pkg.sv
package idxmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRES = 2'd1,
        ST_ARM  = 2'd2,
        ST_MEAS = 2'd3
    } mon_state_e;

    localparam logic [1:0] PR_NONE     = 2'b00;
    localparam logic [1:0] PR_EMPTY    = 2'b01;
    localparam logic [1:0] PR_STOPPED  = 2'b10;
    localparam logic [1:0] PR_SPINNING = 2'b11;
endpackage

// File: rtl/idxmon_sync.sv
module idxmon_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_in;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl  = sy_q.s2;
    assign fall = sy_q.s3 & ~sy_q.s2;

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(sy_q.s1) == 1'b0) else $error("sync delay");   // R1
endmodule

// File: rtl/idxmon_tick_timer.sv
module idxmon_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && (cnt_q == limit - 1'b1);
        cnt_d  = cnt_q;
        if (clear || expire) cnt_d = '0;
        else if (tick)       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> cnt_q < limit) else $error("tick count past limit");   // R6
endmodule

// File: rtl/idxmon_rev_counter.sv
module idxmon_rev_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] total
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        total = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) total = cnt_q + 1'b1;
        cnt_d = clear ? '0 : total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_REV_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt_q >= $past(cnt_q))) else $error("revolution count wrapped");   // R5
endmodule

// File: rtl/idx_rot_monitor.sv
module idx_rot_monitor
    import idxmon_pkg::*;
#(
    parameter int OPEN_TMO    = 4,
    parameter int WIN_SHORT   = 75,
    parameter int WIN_MID     = 300,
    parameter int WIN_LONG    = 600,
    parameter int SHIFT_SHORT = 3,
    parameter int SHIFT_MID   = 1,
    parameter int SHIFT_LONG  = 0,
    parameter int CNT_W       = 12,
    parameter int RPM_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             index_raw,
    input  logic             tick,
    input  logic             start,
    input  logic [1:0]       win_sel,
    output logic [1:0]       presence,
    output logic [RPM_W-1:0] rpm,
    output logic             done,
    output logic             busy
);
    localparam int CLOSED_TMO = 3 * OPEN_TMO;
    localparam int LIM_MAX    = (CLOSED_TMO > WIN_LONG) ? CLOSED_TMO : WIN_LONG;
    localparam int TCNT_W     = $clog2(LIM_MAX + 1);
    localparam logic [RPM_W-1:0] RES_MASK = RPM_W'((1 << SHIFT_SHORT) - 1);

    typedef struct packed {
        mon_state_e       st;
        logic             ref_lvl;
        logic [1:0]       sel;
        logic [1:0]       pres;
        logic [RPM_W-1:0] rpm;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              idx_lvl, idx_fall;
    logic              tmr_clear, tmr_expire;
    logic [TCNT_W-1:0] tmr_limit, win_lim;
    int unsigned       win_shift;
    logic              rev_clear, rev_inc;
    logic [CNT_W-1:0]  rev_total;

    idxmon_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (index_raw),
        .lvl      (idx_lvl),
        .fall     (idx_fall)
    );

    idxmon_tick_timer #(.W(TCNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick),
        .limit  (tmr_limit),
        .expire (tmr_expire)
    );

    idxmon_rev_counter #(.W(CNT_W)) u_revs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rev_clear),
        .inc   (rev_inc),
        .total (rev_total)
    );

    always_comb begin
        case (c_q.sel)
            2'd0:    begin win_lim = TCNT_W'(WIN_SHORT); win_shift = SHIFT_SHORT; end
            2'd1:    begin win_lim = TCNT_W'(WIN_MID);   win_shift = SHIFT_MID;   end
            default: begin win_lim = TCNT_W'(WIN_LONG);  win_shift = SHIFT_LONG;  end
        endcase
        if (c_q.st == ST_PRES)
            tmr_limit = c_q.ref_lvl ? TCNT_W'(OPEN_TMO) : TCNT_W'(CLOSED_TMO);
        else
            tmr_limit = win_lim;
        tmr_clear = !((c_q.st == ST_PRES) || (c_q.st == ST_MEAS));
        rev_clear = (c_q.st != ST_MEAS);
        rev_inc   = (c_q.st == ST_MEAS) && idx_fall;
    end

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st      = ST_PRES;
                    c_d.ref_lvl = idx_lvl;
                    c_d.sel     = win_sel;
                    c_d.pres    = PR_NONE;
                    c_d.rpm     = '0;
                    c_d.done    = 1'b0;
                end
            end
            ST_PRES: begin
                if (idx_lvl != c_q.ref_lvl) begin
                    c_d.pres = PR_SPINNING;
                    c_d.st   = ST_ARM;
                end else if (tmr_expire) begin
                    c_d.pres = c_q.ref_lvl ? PR_EMPTY : PR_STOPPED;
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            ST_ARM: begin
                if (idx_lvl) c_d.st = ST_MEAS;
            end
            ST_MEAS: begin
                if (tmr_expire) begin
                    c_d.rpm  = RPM_W'(rev_total) << win_shift;
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, ref_lvl: 1'b0, sel: 2'd0, pres: PR_NONE,
                             rpm: '0, done: 1'b0};
        else        c_q <= c_d;
    end

    assign presence = c_q.pres;
    assign rpm      = c_q.rpm;
    assign done     = c_q.done;
    assign busy     = (c_q.st != ST_IDLE);

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy");   // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done)) else $error("start not taken");   // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(presence) && $stable(rpm) && $stable(done)))
        else $error("result changed while idle");   // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(c_q.sel)) else $error("start accepted while busy");   // R9
    AST_NO_SPIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && presence != PR_SPINNING) |-> (rpm == '0)) else $error("rpm without spin");   // R2
    AST_SHORT_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_q.sel == 2'd0) |-> ((rpm & RES_MASK) == '0)) else $error("short window resolution");   // R6
endmodule

// File: tb/idx_rot_monitor_test.sv
module idx_rot_monitor_test;
    localparam int OT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic index_raw = 1'b0;
    logic tick = 1'b0;
    logic start = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [1:0] presence;
    logic [15:0] rpm;
    logic done, busy;

    idx_rot_monitor uut (
        .clk(clk), .rst_n(rst_n), .index_raw(index_raw), .tick(tick),
        .start(start), .win_sel(win_sel), .presence(presence), .rpm(rpm),
        .done(done), .busy(busy)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    string cur_req = "R10";

    // stimulus generators
    int tick_per = 4, tph = 0;
    int idx_mode = 0, idx_lvl = 0, idx_per = 12, open_len = 6, iph = 0;

    always @(negedge clk) begin
        tick = (tph == tick_per - 1);
        tph  = (tph + 1) % tick_per;
        if (idx_mode == 1) begin
            index_raw = (iph < open_len);
            iph = (iph + 1) % idx_per;
        end else begin
            index_raw = idx_lvl[0];
        end
    end

    // behavioural reference model
    int m_h1 = 0, m_lvl = 0, m_prev = 0;
    int m_st = 0, m_ref = 0, m_ticks = 0, m_cnt = 0, m_sel = 0;
    int m_pres = 0, m_rpm = 0, m_done = 0;
    int q_win[3] = '{75, 300, 600};
    int q_sh[3]  = '{3, 1, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h1 = 0; m_lvl = 0; m_prev = 0; m_st = 0; m_ref = 0; m_ticks = 0;
            m_cnt = 0; m_sel = 0; m_pres = 0; m_rpm = 0; m_done = 0;
        end else begin
            int fall_now;
            int wi;
            fall_now = (m_prev == 1 && m_lvl == 0);
            wi = (m_sel > 2) ? 2 : m_sel;
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_ref = m_lvl; m_ticks = 0; m_done = 0;
                    m_pres = 0; m_rpm = 0; m_sel = win_sel;
                end
                1: begin
                    if (m_lvl != m_ref) begin
                        m_pres = 3; m_st = 2;
                    end else if (tick) begin
                        m_ticks++;
                        if (m_ticks == (m_ref ? OT : 3 * OT)) begin
                            m_pres = m_ref ? 1 : 2; m_done = 1; m_st = 0;
                        end
                    end
                end
                2: if (m_lvl == 1) begin
                    m_st = 3; m_ticks = 0; m_cnt = 0;
                end
                default: begin
                    if (fall_now) m_cnt++;
                    if (tick) begin
                        m_ticks++;
                        if (m_ticks == q_win[wi]) begin
                            m_rpm = m_cnt << q_sh[wi]; m_done = 1; m_st = 0;
                        end
                    end
                end
            endcase
            m_prev = m_lvl; m_lvl = m_h1; m_h1 = index_raw;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(presence == m_pres[1:0], cur_req, "presence", presence, m_pres);
            check(rpm == m_rpm[15:0], cur_req, "rpm", rpm, m_rpm);
            check(done == m_done[0], cur_req, "done", done, m_done);
            check(busy == (m_st != 0), cur_req, "busy", busy, m_st != 0);
        end
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            summary_and_end();
        end
    end

    task automatic pulse_start(input int sel);
        @(negedge clk); start = 1'b1; win_sel = sel[1:0];
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (m_done == 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(presence == 2'b00 && rpm == 0 && !done && !busy, "R10", "reset outputs",
              {presence, done, busy}, 0);
        rst_n = 1'b1;

        // R2: hole held open -> no disk
        cur_req = "R2"; idx_mode = 0; idx_lvl = 1;
        repeat (4) @(negedge clk);
        pulse_start(0);
        wait_done();
        check(presence == 2'b01, "R2", "no disk class", presence, 1);
        check(rpm == 0, "R2", "no disk rpm", rpm, 0);

        // R8: result holds while idle
        cur_req = "R8";
        repeat (20) @(negedge clk);
        check(done && presence == 2'b01, "R8", "held result", {done, presence}, 5);

        // R3: hole held closed -> stopped, not before open timeout
        cur_req = "R3"; idx_lvl = 0;
        repeat (4) @(negedge clk);
        pulse_start(0);
        check(!done && busy, "R8", "start clears done", done, 0);
        repeat (OT * 4 + 8) @(negedge clk);
        check(busy, "R3", "closed outlives open timeout", busy, 1);
        wait_done();
        check(presence == 2'b10, "R3", "stopped class", presence, 2);

        // R3/R4: closed 35 cycles (< closed timeout) then open -> spinning
        cur_req = "R4"; tick_per = 4;
        @(posedge clk); idx_per = 60; open_len = 20; iph = 25; idx_mode = 1;
        repeat (3) @(negedge clk);
        pulse_start(0);
        wait_done();
        check(presence == 2'b11, "R4", "long closed still spinning", presence, 3);

        // R2 boundary: open 30 cycles (> open timeout) -> no disk
        cur_req = "R2";
        @(posedge clk); idx_per = 60; open_len = 30; iph = 0;
        repeat (3) @(negedge clk);
        pulse_start(0);
        wait_done();
        check(presence == 2'b01, "R2", "long open reads as empty", presence, 1);

        // R5/R6/R9: spinning, short window, start while busy ignored
        cur_req = "R6";
        @(posedge clk); idx_per = 12; open_len = 5; iph = 7;
        repeat (3) @(negedge clk);
        pulse_start(0);
        repeat (100) @(negedge clk);
        cur_req = "R9";
        pulse_start(2);
        cur_req = "R1";
        wait_done();
        check(presence == 2'b11, "R4", "spinning class", presence, 3);
        check(rpm % 8 == 0, "R6", "x8 resolution", rpm, rpm - rpm % 8);
        check(rpm >= 192 && rpm <= 208, "R6", "rpm 75-tick window", rpm, 200);
        check(rpm == 16'(m_cnt << 3), "R5", "revolutions x8", rpm, m_cnt << 3);
        check(rpm <= 208, "R9", "busy start did not change window", rpm, 200);

        // R7: 300-tick window
        cur_req = "R7"; tick_per = 2;
        pulse_start(1);
        wait_done();
        check(rpm >= 98 && rpm <= 102, "R7", "rpm 300-tick window", rpm, 100);
        check(rpm == 16'(m_cnt * 2), "R7", "revolutions x2", rpm, m_cnt * 2);

        // R7: 600-tick window, sel 2 and sel 3
        pulse_start(2);
        wait_done();
        check(rpm >= 99 && rpm <= 101, "R7", "rpm 600-tick window sel2", rpm, 100);
        pulse_start(3);
        wait_done();
        check(rpm >= 99 && rpm <= 101, "R7", "rpm 600-tick window sel3", rpm, 100);
        check(rpm == 16'(m_cnt), "R5", "revolutions x1", rpm, m_cnt);

        summary_and_end();
    end
endmodule